// File: doc/BRIEF.md
# Data Address Watchpoint Unit

This block watches the load/store port of a 32-bit core and raises a debug exception when a data access lands inside a programmed address window. It provides six independent watchpoints. Each has an inclusive lower and upper bound register. Each also has a two-bit trigger field, read and write, packed into one shared control word. A single global enable bit in a mode register gates all six at once. Clearing that bit stops every watchpoint without losing any of its programming.

When an enabled watchpoint matches, the unit latches an exception flag. It records the cause code 0x0C in the status register and keeps the access address in a capture register. The flag and the address stay put until software writes the status register, so a second hit cannot overwrite the first.

Registers are reached through a plain write strobe with a 4-bit select, and are read back through a combinational data bus.

Top module: `dwatch_unit`

## Requirements
- R1: After reset, all of these read zero: the control word (select 0), the mode register (select 1), the status register (select 2), the capture register (select 3) and every bound register (selects 4 to 15, lower bound of watchpoint n at 4+2n and upper bound at 5+2n). The exception output is low after reset.
- R2: Watchpoint n takes its trigger field from control bits [3+4n:2+4n]. The low bit of the field arms it for reads (acc_write=0) and the high bit arms it for writes (acc_write=1). With both bits set it fires on either direction.
- R3: A watchpoint whose two-bit field is zero never fires, whatever its bounds.
- R4: An access matches when lower ≤ address ≤ upper under unsigned comparison, so both bounds are inside the window. Bound values at or above 0x8000_0000 behave as large unsigned numbers.
- R5: Matching happens only while mode bit 19 is set. While it is clear, no access fires, and the control and bound registers keep their values.
- R6: A matching access sampled at a clock edge drives dbg_exc high right after that edge. The status register then reads 0x0000_0C00, with cause code 0x0C in bits [15:8].
- R7: On the hit that raises the exception, the capture register and dbg_addr take the address of that access.
- R8: While the exception is pending, later hits leave dbg_exc high and leave the captured address unchanged.
- R9: Any write to the status register clears dbg_exc and the cause field. If a matching access happens in the same cycle as that write, the exception is raised again and the new address is captured.
- R10: When several watchpoints match one access, a single exception is raised and the access address is captured.
- R11: Control bits outside the six trigger fields always read zero, giving a readable control mask of 0x00CC_CCCC. Mode register bits other than bit 19 always read zero.
- R12: An address presented with acc_valid low never fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_sel |
| acc_valid | input | 1 | Data access present this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 32 | First-byte address of the access |
| dbg_exc | output | 1 | Debug exception pending |
| dbg_addr | output | 32 | Captured data address |

## Verification
A wrong trigger field or bound shows up one cycle after the offending access. In that case dbg_exc either rises when it should not or stays low, so each access is scored at the edge that follows it. A corrupted capture or a lost hold shows up at dbg_addr on the next hit, because a correct unit keeps its first address there. Faults in masking or retention are only visible through register readback, so the bench reads the control, mode and bound registers back after toggling the global enable and after writing all-ones.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;
  localparam int ADDR_W       = 32;
  localparam int WORD_W       = 32;
  localparam int FIELD_BASE   = 2;
  localparam int FIELD_STRIDE = 4;
  localparam int GEN_EN_BIT   = 19;
  localparam int CAUSE_W      = 8;
  localparam int CAUSE_LSB    = 8;
  localparam logic [CAUSE_W-1:0] CAUSE_WATCH = 8'h0C;

  localparam int SEL_CTRL    = 0;
  localparam int SEL_MODE    = 1;
  localparam int SEL_STATUS  = 2;
  localparam int SEL_CAPTURE = 3;
  localparam int SEL_RANGE   = 4;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [WORD_W-1:0] word_t;

  // bit position of the read-enable bit of watchpoint n
  function automatic int field_lsb(input int n);
    return FIELD_BASE + FIELD_STRIDE * n;
  endfunction

  // unsigned, inclusive at both ends
  function automatic logic in_window(input addr_t lo, input addr_t hi, input addr_t a);
    return (a >= lo) && (a <= hi);
  endfunction

  // low bit arms reads, high bit arms writes
  function automatic logic dir_armed(input logic [1:0] fld, input logic is_wr);
    return is_wr ? fld[1] : fld[0];
  endfunction

  function automatic word_t ctrl_mask(input int nwp);
    word_t m;
    m = '0;
    for (int n = 0; n < nwp; n++) begin
      m[field_lsb(n)]     = 1'b1;
      m[field_lsb(n) + 1] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/dwatch_cmp.sv
module dwatch_cmp
  import dwatch_pkg::*;
(
  input  logic [1:0] field,
  input  addr_t      lo,
  input  addr_t      hi,
  input  logic       gen_en,
  input  logic       acc_valid,
  input  logic       acc_write,
  input  addr_t      acc_addr,
  output logic       hit
);
  logic armed_w;
  logic inside_w;

  always_comb begin
    armed_w  = dir_armed(field, acc_write);
    inside_w = in_window(lo, hi, acc_addr);
    hit      = gen_en && acc_valid && armed_w && inside_w;
  end
endmodule

// File: rtl/dwatch_regs.sv
module dwatch_regs
  import dwatch_pkg::*;
#(
  parameter int NUM_WP = 6,
  parameter int SEL_W  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reg_wr,
  input  logic [SEL_W-1:0]               reg_sel,
  input  word_t                          reg_wdata,
  output word_t                          ctrl_q,
  output logic                           gen_en_q,
  output logic [NUM_WP-1:0][ADDR_W-1:0]  lo_q,
  output logic [NUM_WP-1:0][ADDR_W-1:0]  hi_q,
  output logic                           status_clr
);
  localparam word_t MASK = ctrl_mask(NUM_WP);

  logic wr_ctrl, wr_mode;

  always_comb begin
    wr_ctrl    = reg_wr && (int'(reg_sel) == SEL_CTRL);
    wr_mode    = reg_wr && (int'(reg_sel) == SEL_MODE);
    status_clr = reg_wr && (int'(reg_sel) == SEL_STATUS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      gen_en_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q   <= reg_wdata & MASK;
      if (wr_mode) gen_en_q <= reg_wdata[GEN_EN_BIT];
    end
  end

  for (genvar n = 0; n < NUM_WP; n++) begin : g_bound
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[n] <= '0;
        hi_q[n] <= '0;
      end else if (reg_wr) begin
        if (int'(reg_sel) == SEL_RANGE + 2*n)     lo_q[n] <= reg_wdata;
        if (int'(reg_sel) == SEL_RANGE + 2*n + 1) hi_q[n] <= reg_wdata;
      end
    end
  end
endmodule

// File: rtl/dwatch_event.sv
module dwatch_event
  import dwatch_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               any_hit,
  input  addr_t              acc_addr,
  input  logic               status_clr,
  output logic               pending_q,
  output logic [CAUSE_W-1:0] cause_q,
  output addr_t              cap_q,
  output logic               fire
);
  always_comb fire = any_hit && (!pending_q || status_clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      cause_q   <= '0;
      cap_q     <= '0;
    end else if (fire) begin
      pending_q <= 1'b1;
      cause_q   <= CAUSE_WATCH;
      cap_q     <= acc_addr;
    end else if (status_clr) begin
      pending_q <= 1'b0;
      cause_q   <= '0;
    end
  end
endmodule

// File: rtl/dwatch_unit.sv
module dwatch_unit
  import dwatch_pkg::*;
#(
  parameter int NUM_WP = 6,
  localparam int SEL_W = $clog2(SEL_RANGE + 2*NUM_WP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [31:0]      acc_addr,
  output logic             dbg_exc,
  output logic [31:0]      dbg_addr
);
  word_t                          ctrl_q;
  logic                           gen_en_q;
  logic [NUM_WP-1:0][ADDR_W-1:0]  lo_q, hi_q;
  logic                           status_clr;
  logic [NUM_WP-1:0]              hit_vec;
  logic                           any_hit;
  logic                           pending_q;
  logic [CAUSE_W-1:0]             cause_q;
  addr_t                          cap_q;
  logic                           fire;

  dwatch_regs #(.NUM_WP(NUM_WP), .SEL_W(SEL_W)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata,
    .ctrl_q, .gen_en_q, .lo_q, .hi_q, .status_clr
  );

  for (genvar n = 0; n < NUM_WP; n++) begin : g_cmp
    dwatch_cmp u_cmp (
      .field     (ctrl_q[field_lsb(n) +: 2]),
      .lo        (lo_q[n]),
      .hi        (hi_q[n]),
      .gen_en    (gen_en_q),
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_addr  (acc_addr),
      .hit       (hit_vec[n])
    );
  end

  always_comb any_hit = |hit_vec;

  dwatch_event u_event (
    .clk, .rst_n, .any_hit, .acc_addr, .status_clr,
    .pending_q, .cause_q, .cap_q, .fire
  );

  always_comb begin
    reg_rdata = '0;
    case (int'(reg_sel))
      SEL_CTRL:    reg_rdata = ctrl_q;
      SEL_MODE:    reg_rdata[GEN_EN_BIT] = gen_en_q;
      SEL_STATUS:  reg_rdata[CAUSE_LSB +: CAUSE_W] = cause_q;
      SEL_CAPTURE: reg_rdata = cap_q;
      default: begin
        for (int n = 0; n < NUM_WP; n++) begin
          if (int'(reg_sel) == SEL_RANGE + 2*n)     reg_rdata = lo_q[n];
          if (int'(reg_sel) == SEL_RANGE + 2*n + 1) reg_rdata = hi_q[n];
        end
      end
    endcase
  end

  assign dbg_exc  = pending_q;
  assign dbg_addr = cap_q;
endmodule

// File: rtl/dwatch_unit_chk.sv
module dwatch_unit_chk
  import dwatch_pkg::*;
#(
  parameter int NUM_WP = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input addr_t              acc_addr,
  input word_t              ctrl_q,
  input logic               gen_en_q,
  input logic [NUM_WP-1:0]  hit_vec,
  input logic               any_hit,
  input logic               status_clr,
  input logic               pending_q,
  input logic [CAUSE_W-1:0] cause_q,
  input addr_t              cap_q
);
  p_hit_sets_exc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |=> pending_q);

  p_cause_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |-> cause_q == CAUSE_WATCH);

  p_capture_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (any_hit && (!pending_q || status_clr)) |=> cap_q == $past(acc_addr));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !status_clr) |=> (pending_q && $stable(cap_q)));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && !any_hit) |=> !pending_q);

  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en_q |-> hit_vec == '0);

  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !any_hit);

  for (genvar n = 0; n < NUM_WP; n++) begin : g_free
    p_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[field_lsb(n) +: 2] == 2'b00) |-> !hit_vec[n]);
  end
endmodule

bind dwatch_unit dwatch_unit_chk #(.NUM_WP(NUM_WP)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .ctrl_q(ctrl_q), .gen_en_q(gen_en_q), .hit_vec(hit_vec), .any_hit(any_hit),
  .status_clr(status_clr), .pending_q(pending_q), .cause_q(cause_q), .cap_q(cap_q)
);

// File: tb/dwatch_unit_test.sv
module dwatch_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NWP = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        dbg_exc;
  logic [31:0] dbg_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic        exc;
    logic [31:0] addr;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // reference model state
  logic [31:0] m_ctrl = '0;
  logic        m_gen = 1'b0;
  logic [31:0] m_lo [NWP];
  logic [31:0] m_hi [NWP];
  logic        m_pend = 1'b0;
  logic [31:0] m_cap = '0;

  dwatch_unit uut (
    .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata, .reg_rdata,
    .acc_valid, .acc_write, .acc_addr, .dbg_exc, .dbg_addr
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic model_hit(input logic w, input logic [31:0] a);
    logic h;
    h = 1'b0;
    for (int n = 0; n < NWP; n++) begin
      logic [1:0] f;
      f = 2'((m_ctrl >> (2 + 4*n)) & 32'h3);
      if ((w ? f[1] : f[0]) && a >= m_lo[n] && a <= m_hi[n]) h = 1'b1;
    end
    return m_gen && h;
  endfunction

  // monitor: score one expectation per edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({31'b0, dbg_exc}, {31'b0, e.exc}, {e.tag, " exc"});
      check(dbg_addr, e.addr, {e.tag, " addr"});
    end
  end

  task automatic reg_write(input int sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 4'(sel); reg_wdata = d;
    case (sel)
      0: m_ctrl = d & 32'h00CC_CCCC;
      1: m_gen = d[19];
      2: m_pend = 1'b0;
      default: if (sel >= 4) begin
        if (sel % 2 == 0) m_lo[(sel-4)/2] = d; else m_hi[(sel-4)/2] = d;
      end
    endcase
    if (sel == 2) sb.push_back('{m_pend, m_cap, "R9 clear"});
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_check(input int sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_sel = 4'(sel);
    #1;
    check(reg_rdata, exp, tag);
  endtask

  task automatic access(input logic v, input logic w, input logic [31:0] a,
                        input logic clr, input string tag);
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_addr = a;
    reg_wr = clr; reg_sel = 4'd2; reg_wdata = '0;
    if (clr) m_pend = 1'b0;
    if (v && model_hit(w, a) && !m_pend) begin
      m_pend = 1'b1;
      m_cap  = a;
    end
    sb.push_back('{m_pend, m_cap, tag});
    @(negedge clk);
    acc_valid = 1'b0; reg_wr = 1'b0;
  endtask

  initial begin
    for (int n = 0; n < NWP; n++) begin m_lo[n] = '0; m_hi[n] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check({31'b0, dbg_exc}, 32'd0, "R1 exc");
    for (int s = 0; s < 16; s++) reg_check(s, 32'd0, "R1 readback");

    // R11 masks
    reg_write(0, 32'hFFFF_FFFF);
    reg_check(0, 32'h00CC_CCCC, "R11 ctrl mask");
    reg_write(1, 32'hFFFF_FFFF);
    reg_check(1, 32'h0008_0000, "R11 mode mask");
    reg_write(0, 32'h0);

    // wp0 read-only over 0x1000..0x100F
    reg_write(4, 32'h1000);
    reg_write(5, 32'h100F);
    reg_write(0, 32'h4);
    access(1, 1, 32'h1004, 0, "R2 write on read-only");
    access(1, 0, 32'h1004, 0, "R6 R7 read hit");
    reg_check(2, 32'h0000_0C00, "R6 status");
    reg_check(3, 32'h1004, "R7 capture reg");
    access(1, 0, 32'h1008, 0, "R8 hold");
    reg_write(2, 32'h0);
    reg_check(2, 32'h0, "R9 cause cleared");

    // R4 bounds
    access(1, 0, 32'h0FFF, 0, "R4 below");
    access(1, 0, 32'h1000, 0, "R4 lower edge");
    reg_write(2, 0);
    access(1, 0, 32'h100F, 0, "R4 upper edge");
    reg_write(2, 0);
    access(1, 0, 32'h1010, 0, "R4 above");

    // wp1 write-only, field at bits 7:6
    reg_write(6, 32'h2000);
    reg_write(7, 32'h2003);
    reg_write(0, 32'h4 | 32'h80);
    access(1, 0, 32'h2000, 0, "R2 read on write-only");
    access(1, 1, 32'h2002, 0, "R2 write hit");
    reg_write(2, 0);

    // R3 free slot
    reg_write(8, 32'h3000);
    reg_write(9, 32'h3FFF);
    access(1, 0, 32'h3100, 0, "R3 free read");
    access(1, 1, 32'h3100, 0, "R3 free write");

    // R5 global gate
    reg_write(1, 32'h0);
    access(1, 0, 32'h1000, 0, "R5 gated");
    reg_check(0, 32'h84, "R5 ctrl kept");
    reg_check(5, 32'h100F, "R5 bound kept");
    reg_write(1, 32'h0008_0000);

    // R12 idle
    access(0, 0, 32'h1000, 0, "R12 not valid");

    // R10 overlap: wp3 any access 0x2000..0x20FF
    reg_write(10, 32'h2000);
    reg_write(11, 32'h20FF);
    reg_write(0, 32'h84 | 32'hC000);
    access(1, 1, 32'h2001, 0, "R10 double match");

    // R9 clear plus same-cycle hit
    access(1, 0, 32'h1003, 1, "R9 clear with hit");
    reg_write(2, 0);

    // R4 unsigned high range, wp4 at bits 19:18
    reg_write(12, 32'h8000_0000);
    reg_write(13, 32'hFFFF_FFFF);
    reg_write(0, 32'h84 | 32'hC000 | 32'hC_0000);
    access(1, 0, 32'h7FFF_FFFF, 0, "R4 unsigned below");
    access(1, 1, 32'hFFFF_FFFF, 0, "R4 unsigned top");

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule